// File: doc/BRIEF.md
# I2C Slave Register Port with Clock Freeze

This block is an I2C target that exposes a 64-byte register space to a bus master. Bytes 00h to 07h are a user-visible copy of a set of live timekeeping counters; bytes 08h to 3Fh are plain RAM. The block samples SCL and SDA through synchronizers, detects START, repeated START and STOP, answers only the 7-bit device address 1101000b, and keeps a word-address pointer that is loaded by write transfers and advanced automatically. Random reads, current-address reads, sequential reads and multi-byte writes are supported.

The counter logic lives outside the block. It presents all eight clock bytes on a parallel bus together with a one-cycle update strobe. The copy into the user bytes is held off while a transfer is in progress and the pointer sits in the clock range, so a master reading the time sees one coherent snapshot. A strobe that arrives during the hold is kept, and its captured value is applied in one cycle when the hold ends. The hold ends on STOP or when the pointer leaves 00h–07h.

Top module: `i2c_clkreg_port`

## Requirements
- R1: A header byte whose upper seven bits equal 1101000b is acknowledged by pulling SDA low in the ninth clock. Any other header gets no acknowledge, and the block does not drive SDA until the next START.
- R2: After a write header (bit 0 = 0), the first data byte is acknowledged and its low six bits are loaded into the pointer. Bits 7:6 are ignored.
- R3: Each further byte of a write transfer is stored at the pointer and acknowledged, and the pointer then increments.
- R4: A write header plus word address, followed by a repeated START and a read header (bit 0 = 1), makes the block transmit the byte at that word address, MSB first.
- R5: When the master acknowledges a transmitted byte (SDA low in the ninth clock), the pointer increments and the next byte is transmitted, so a read returns An, An+1, An+2 and so on until STOP.
- R6: A master NACK (SDA high in the ninth clock) ends transmission. SDA is released and the pointer does not advance.
- R7: A read header with no preceding word address returns the byte at the current pointer value.
- R8: The pointer wraps from 3Fh to 00h, for both reads and writes.
- R9: When not frozen, a pulse on live_upd_i copies live_time_i into bytes 00h–07h in one cycle. Byte k takes live_time_i[8k+7:8k].
- R10: From an address match until STOP, while the pointer is in 00h–07h, update strobes leave bytes 00h–07h unchanged.
- R11: A strobe that arrives during the freeze is applied with the value captured at that strobe, once, when the freeze ends. The freeze ends on STOP or when the pointer increments past 07h within the transfer.
- R12: The block changes SDA only while SCL is low. An SDA fall while SCL is high is a START and an SDA rise while SCL is high is a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| live_time_i | input | 64 | Live counter bytes; byte k in bits 8k+7:8k |
| live_upd_i | input | 1 | One-cycle strobe: live_time_i holds a new value |

## Verification
The bench targets these cases:
- A NACK on the last read byte. A design that advanced the pointer there would make the next current-address read return the following byte.
- A write that crosses 3Fh. A missing wrap would land the data outside the space, so the readback of 00h would differ.
- An update strobe while the pointer points at clock bytes. A design without the freeze returns the new time inside the same transfer.
- The same strobe after STOP. A design that drops a held strobe keeps the old time after STOP.
- A read that walks from 07h into 08h. Releasing only on STOP would leave the held value unapplied when the clock bytes are re-read inside the same transfer.
- A foreign header. It must draw no acknowledge.

// File: rtl/i2c_clkreg_pkg.sv
package i2c_clkreg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_TX,
    ST_TX_ACK
  } slv_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data edge while clock stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_clkreg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h68
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              session_o,
  output logic              sda_oe_o
);
  slv_state_e        st_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              rw_q, tx_acked_q, session_q, oe_q;
  logic              byte_done, ptr_load;

  assign byte_done = scl_fall_i && (cnt_q == 4'd8);
  assign ptr_load  = (st_q == ST_WADR) && byte_done;
  assign wr_en_o   = (st_q == ST_WDAT) && byte_done;
  assign wr_data_o = sh_q;
  assign ptr_o     = ptr_q;
  assign session_o = session_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      ptr_q      <= '0;
      rw_q       <= 1'b0;
      tx_acked_q <= 1'b0;
      session_q  <= 1'b0;
      oe_q       <= 1'b0;
    end else if (stop_i) begin
      st_q      <= ST_IDLE;
      oe_q      <= 1'b0;
      session_q <= 1'b0;
    end else if (start_i) begin
      st_q  <= ST_ADDR;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WADR, ST_WDAT: begin
          if (scl_rise_i && cnt_q != 4'd8) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            cnt_q <= '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                st_q      <= ST_ADDR_ACK;
                oe_q      <= 1'b1;
                rw_q      <= sh_q[0];
                session_q <= 1'b1;
              end else begin
                st_q      <= ST_IDLE;
                session_q <= 1'b0;
              end
            end else if (st_q == ST_WADR) begin
              ptr_q <= sh_q[ADDR_W-1:0];
              st_q  <= ST_WADR_ACK;
              oe_q  <= 1'b1;
            end else begin
              ptr_q <= ptr_q + 1'b1;
              st_q  <= ST_WDAT_ACK;
              oe_q  <= 1'b1;
            end
          end
        end
        ST_ADDR_ACK, ST_WADR_ACK, ST_WDAT_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (st_q == ST_ADDR_ACK && rw_q) begin
              st_q <= ST_TX;
              sh_q <= rd_data_i;
              oe_q <= ~rd_data_i[7];
            end else begin
              st_q <= (st_q == ST_ADDR_ACK) ? ST_WADR : ST_WDAT;
              oe_q <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              cnt_q <= '0;
              oe_q  <= 1'b0;
              st_q  <= ST_TX_ACK;
            end else begin
              cnt_q <= cnt_q + 4'd1;
              sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
              oe_q  <= ~sh_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            tx_acked_q <= ~sda_i;
            if (!sda_i) ptr_q <= ptr_q + 1'b1;
          end else if (scl_fall_i) begin
            if (tx_acked_q) begin
              st_q <= ST_TX;
              sh_q <= rd_data_i;
              oe_q <= ~rd_data_i[7];
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_ack_only_when_owed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> (st_q inside {ST_ADDR_ACK, ST_WADR_ACK, ST_WDAT_ACK, ST_TX}));

  assert_sda_moves_scl_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_i);

  assert_ptr_load_or_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q != $past(ptr_q)) && !$past(ptr_load) |-> ptr_q == $past(ptr_q) + 1'b1);

  assert_nack_holds_ptr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TX_ACK) && scl_rise_i && sda_i && !start_i && !stop_i |=> ptr_q == $past(ptr_q));
endmodule

// File: rtl/clkreg_mem.sv
module clkreg_mem
  import i2c_clkreg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned CLK_BYTES = 8,
  localparam int unsigned DEPTH    = 1 << ADDR_W,
  localparam int unsigned LIVE_W   = CLK_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic [LIVE_W-1:0] live_time_i,
  input  logic              live_upd_i,
  input  logic              freeze_i
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [LIVE_W-1:0] pend_buf_q, src;
  logic [LIVE_W-1:0] clk_view;
  logic              pend_q, apply;

  assign apply = !freeze_i && (live_upd_i || pend_q);
  assign src   = live_upd_i ? live_time_i : pend_buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i < CLK_BYTES && apply)
          mem_q[i] <= src[i*BYTE_W +: BYTE_W];
        else if (wr_en_i && wr_addr_i == ADDR_W'(i))
          mem_q[i] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_buf_q <= '0;
    end else if (freeze_i) begin
      if (live_upd_i) begin
        pend_q     <= 1'b1;
        pend_buf_q <= live_time_i;
      end
    end else begin
      pend_q <= 1'b0;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  for (genvar k = 0; k < CLK_BYTES; k++) begin : g_view
    assign clk_view[k*BYTE_W +: BYTE_W] = mem_q[k];
  end

  assert_live_copy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i && live_upd_i |=> clk_view == $past(live_time_i));

  assert_frozen_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i && !wr_en_i |=> $stable(clk_view));

  assert_held_applied_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i && pend_q && !live_upd_i |=> clk_view == $past(pend_buf_q));
endmodule

// File: rtl/i2c_clkreg_port.sv
module i2c_clkreg_port
  import i2c_clkreg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned CLK_BYTES = 8,
  parameter logic [6:0]  DEV_ADDR  = 7'h68,
  parameter int unsigned SYNC_STG  = 2,
  localparam int unsigned LIVE_W   = CLK_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [LIVE_W-1:0] live_time_i,
  input  logic              live_upd_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic wr_en, session, freeze;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [ADDR_W-1:0] ptr;

  i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_slave_fsm #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_data_o(wr_data), .ptr_o(ptr),
    .session_o(session), .sda_oe_o
  );

  assign freeze = session && (ptr < ADDR_W'(CLK_BYTES));

  clkreg_mem #(.ADDR_W(ADDR_W), .CLK_BYTES(CLK_BYTES)) u_mem (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(ptr), .wr_data_i(wr_data),
    .rd_addr_i(ptr), .rd_data_o(rd_data), .live_time_i, .live_upd_i,
    .freeze_i(freeze)
  );

  assert_stop_unfreezes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !freeze);
endmodule

// File: tb/tb_i2c_clkreg_port.sv
module tb_i2c_clkreg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [63:0] live = '0;
  logic upd = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int n_tests = 0, n_fail = 0, edge_viol = 0;
  logic [7:0] mem_m [64];
  logic [5:0] ptr_m = '0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_clkreg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .live_time_i(live), .live_upd_i(upd)
  );

  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (rst_n && scl_m && sda_oe != oe_prev) edge_viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] byte_of(logic [63:0] v, int k);
    return v[k*8 +: 8];
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (8) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); wq();
    sda_m = 1'b0; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b; wq(); scl_m = 1'b1; wq(); s = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
    clock_bit(~mack, s);
  endtask

  task automatic pulse_upd(input logic [63:0] v);
    @(negedge clk); live = v; upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  // write header + word address + data bytes
  task automatic wr_seq(input logic [5:0] a, input int n, input logic [7:0] d [4], string tag);
    logic ack;
    i2c_start();
    write_byte(8'hD0, ack); chk(ack, {tag, " R1 hdr ack"}, ack, 1);
    write_byte({2'b00, a}, ack); chk(ack, {tag, " R2 wadr ack"}, ack, 1);
    ptr_m = a;
    for (int i = 0; i < n; i++) begin
      write_byte(d[i], ack); chk(ack, {tag, " R3 data ack"}, ack, 1);
      mem_m[ptr_m] = d[i];
      ptr_m = ptr_m + 1'b1;
    end
    i2c_stop();
  endtask

  // optional word address, then read n bytes, last one NACKed
  task automatic rd_seq(input bit set_adr, input logic [5:0] a, input int n, string tag);
    logic ack;
    logic [7:0] b;
    i2c_start();
    if (set_adr) begin
      write_byte(8'hD0, ack);
      write_byte(a, ack);
      ptr_m = a;
      i2c_start();
    end
    write_byte(8'hD1, ack); chk(ack, {tag, " R1 rd hdr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      read_byte(i != n - 1, b);
      chk(b == mem_m[ptr_m], tag, b, mem_m[ptr_m]);
      if (i != n - 1) ptr_m = ptr_m + 1'b1;
    end
    i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic [7:0] d [4];
    logic [63:0] v0, v1, v2;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 64; i++) mem_m[i] = 8'h00;

    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: foreign address is not acknowledged
    i2c_start();
    write_byte(8'hA0, ack); chk(!ack, "R1 foreign hdr", ack, 0);
    write_byte(8'h00, ack); chk(!ack, "R1 foreign data", ack, 0);
    i2c_stop();

    // R2 bits 7:6 ignored, R3 multi-byte write
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    i2c_start();
    write_byte(8'hD0, ack); chk(ack, "R1 hdr", ack, 1);
    write_byte(8'hD0, ack); chk(ack, "R2 wadr", ack, 1); // loads 10h
    ptr_m = 6'h10;
    for (int i = 0; i < 3; i++) begin
      write_byte(d[i], ack); chk(ack, "R3 data", ack, 1);
      mem_m[ptr_m] = d[i]; ptr_m++;
    end
    i2c_stop();

    rd_seq(1, 6'h11, 1, "R4 random read");
    rd_seq(0, 6'h00, 1, "R6 R7 current after nack");
    rd_seq(1, 6'h10, 3, "R5 sequential read");
    rd_seq(0, 6'h00, 1, "R7 current read");

    // R8: write and read across 3Fh
    d = '{8'hA5, 8'h5A, 8'h00, 8'h00};
    wr_seq(6'h3F, 2, d, "R8 wrap write");
    rd_seq(1, 6'h3F, 2, "R8 wrap read");

    // R9: copy outside a transfer
    v0 = 64'h0807_0605_0403_0201;
    pulse_upd(v0);
    for (int k = 0; k < 8; k++) mem_m[k] = byte_of(v0, k);
    rd_seq(1, 6'h00, 8, "R9 live copy");

    // R10 hold while pointer on clock bytes, R11 applied on STOP
    v1 = 64'hF1E2_D3C4_B5A6_9788;
    i2c_start();
    write_byte(8'hD0, ack); write_byte(8'h03, ack);
    pulse_upd(v1);
    i2c_start();
    write_byte(8'hD1, ack);
    read_byte(1'b1, b); chk(b == byte_of(v0, 3), "R10 frozen byte3", b, byte_of(v0, 3));
    read_byte(1'b0, b); chk(b == byte_of(v0, 4), "R10 frozen byte4", b, byte_of(v0, 4));
    i2c_stop();
    for (int k = 0; k < 8; k++) mem_m[k] = byte_of(v1, k);
    rd_seq(1, 6'h03, 1, "R11 applied on stop");

    // R11: release when pointer moves past 07h
    v2 = 64'h1357_9BDF_2468_ACE0;
    i2c_start();
    write_byte(8'hD0, ack); write_byte(8'h06, ack);
    pulse_upd(v2);
    i2c_start();
    write_byte(8'hD1, ack);
    read_byte(1'b1, b); chk(b == byte_of(v1, 6), "R10 frozen byte6", b, byte_of(v1, 6));
    read_byte(1'b1, b); chk(b == byte_of(v1, 7), "R10 frozen byte7", b, byte_of(v1, 7));
    read_byte(1'b0, b); chk(b == mem_m[8], "R5 byte8", b, mem_m[8]);
    i2c_start();
    write_byte(8'hD0, ack); write_byte(8'h00, ack);
    i2c_start();
    write_byte(8'hD1, ack);
    read_byte(1'b0, b); chk(b == byte_of(v2, 0), "R11 applied on crossing", b, byte_of(v2, 0));
    i2c_stop();
    for (int k = 0; k < 8; k++) mem_m[k] = byte_of(v2, k);

    // random RAM traffic with interleaved live updates
    for (int it = 0; it < 14; it++) begin
      int n;
      logic [5:0] a;
      n = 1 + int'($urandom_range(3));
      a = 6'(8 + $urandom_range(63 - 8 - n));
      for (int i = 0; i < 4; i++) d[i] = 8'($urandom);
      wr_seq(a, n, d, "R3 rand write");
      rd_seq(1, a, n, "R5 rand read");
      if (it % 3 == 0) begin
        v0 = {$urandom, $urandom};
        pulse_upd(v0);
        for (int k = 0; k < 8; k++) mem_m[k] = byte_of(v0, k);
        rd_seq(1, 6'($urandom_range(7)), 1, "R9 rand live");
      end
    end

    chk(edge_viol == 0, "R12 sda change with scl high", edge_viol, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule